// File: doc/BRIEF.md
# SPI Master Event and FIFO Status Unit

This block sits between a register port and the serial shift engine of an SPI master. It keeps a transmit FIFO and a receive FIFO of 32-bit words. It also keeps a sticky event word that software clears by writing ones, an interrupt mask, and a mode word. The mode word holds the interface enable and two FIFO threshold fields.

Software writes transmit words and reads received words through the register port. The shift engine takes words from the transmit FIFO and pushes received words into the receive FIFO. Each received word carries a count of its valid bytes, from 1 to 4, so a final partial word can be stored. The event word reports four conditions: transmit room, receive data present, frame done and transmit FIFO drained. It also reports the total number of valid bytes held in the receive FIFO. Clearing the enable bit empties both FIFOs and zeroes that byte count.

Top module: `spi_evt_stat`

## Requirements
- R1: Event bit 8 (tx room) is set one cycle after the tx FIFO is not full. A write-one clear does not stick while the FIFO still has room. With the FIFO full, a write-one clear leaves it at 0.
- R2: Event bit 9 (rx data present) is set one cycle after the rx FIFO holds an entry. It stays set after the FIFO empties until a 1 is written to bit 9 of the event word at address 1.
- R3: Event bit 15 (tx drained) is set one cycle after the tx FIFO is empty. A write-one clear leaves it at 0 while the FIFO holds data.
- R4: Event bit 14 (frame done) is set in the cycle after a pulse on eng_frame_done_i. It stays set through writes that carry 0 at bit 14. Writing 1 at bit 14 clears it, and so does writing 0xFFFFFFFF.
- R5: Event bits 29:24 give the total valid bytes in the rx FIFO. Each accepted push adds eng_rx_bytes_i, where code 0 means 4 bytes. A push into a full rx FIFO is dropped.
- R6: A read of address 4 returns the oldest rx word and pops it, which lowers the byte count by that word's byte count. A read of address 4 on an empty FIFO returns 0 and changes nothing.
- R7: A write to address 3 pushes a tx word. The engine sees the oldest word on eng_tx_data_o with eng_tx_valid_o high. eng_tx_pop_i removes that word, and a write to a full tx FIFO is dropped.
- R8: Mode bit 31 (address 0) enables the unit. While it is 0 both FIFOs are held empty and the byte count is 0. Tx writes and rx pushes are ignored, so re-enabling starts from empty FIFOs.
- R9: The mode word reads back bit 31, the rx threshold in bits 5:0 and the tx threshold in bits 13:8. All other bits read 0. The mask register (address 2) reads back all 32 bits.
- R10: irq_o is the OR of the four event flags, each ANDed with the mask bit at the same position. A mask of zero keeps irq_o low.
- R11: After reset, mode, mask and event all read 0, irq_o is low and eng_tx_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops rx at address 4) |
| reg_addr_i | input | 3 | Register address: 0 mode, 1 event, 2 mask, 3 tx data, 4 rx data |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| eng_tx_valid_o | output | 1 | Tx FIFO holds a word for the engine |
| eng_tx_data_o | output | 32 | Oldest tx word |
| eng_tx_pop_i | input | 1 | Engine takes the oldest tx word |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | 32 | Received word |
| eng_rx_bytes_i | input | 2 | Valid bytes in the received word, 0 meaning 4 |
| eng_frame_done_i | input | 1 | Frame-done pulse from the engine |
| irq_o | output | 1 | Masked event interrupt |

## Verification
Some properties are checked on every cycle. Each status flag follows its FIFO condition one cycle later. A frame-done pulse sets its flag. A disabled unit holds a zero byte count, the count never exceeds the rx capacity, every single push or pop moves the count by exactly that entry's byte count, and a zero mask keeps the interrupt low. Other behaviour only the bench scenarios can show. These are FIFO data ordering, dropped writes and pushes at full, the sticky behaviour of flags once their condition has gone, write-one-clear selectivity, the mode and mask readback layout, and the full mask-to-interrupt table.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned THR_W  = 6;
  localparam int unsigned NFLAG  = 4;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TXD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RXD   = 3'd4;

  // flag vector index -> event word bit
  localparam int unsigned IDX_ROOM  = 0;
  localparam int unsigned IDX_AVAIL = 1;
  localparam int unsigned IDX_DONE  = 2;
  localparam int unsigned IDX_DRAIN = 3;
  localparam int unsigned FLAG_POS [NFLAG] = '{8, 9, 14, 15};

  localparam int unsigned EV_CNT_LSB = 24;
  localparam int unsigned EV_CNT_W   = 6;

  localparam int unsigned MODE_EN_BIT = 31;
  localparam int unsigned MODE_RX_LSB = 0;
  localparam int unsigned MODE_TX_LSB = 8;
endpackage

// File: rtl/spi_evt_fifo.sv
module spi_evt_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_ptr_q] <= wdata_i;
  end
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags #(
  parameter int unsigned NFLAG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic [NFLAG-1:0] clr_i,
  output logic [NFLAG-1:0] flags_o
);
  // set wins over a simultaneous clear
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_o[i] <= 1'b0;
      else         flags_o[i] <= (flags_o[i] && !clr_i[i]) || set_i[i];
    end
  end
endmodule

// File: rtl/spi_evt_stat.sv
module spi_evt_stat
  import spi_evt_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 4,
  parameter int unsigned RX_DEPTH = 8  // 4*RX_DEPTH must fit the 6-bit byte field
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              eng_tx_valid_o,
  output logic [31:0]       eng_tx_data_o,
  input  logic              eng_tx_pop_i,
  input  logic              eng_rx_push_i,
  input  logic [31:0]       eng_rx_data_i,
  input  logic [1:0]        eng_rx_bytes_i,
  input  logic              eng_frame_done_i,
  output logic              irq_o
);
  localparam int unsigned RXB_W    = $clog2(4 * RX_DEPTH + 1);
  localparam int unsigned RX_ENT_W = WORD_W + 3;

  logic              en_q;
  logic [THR_W-1:0]  rx_thr_q, tx_thr_q;
  logic [WORD_W-1:0] mask_q;
  logic [RXB_W-1:0]  rx_bytes_q;

  logic wr_mode, wr_event, wr_mask, wr_txd, rd_rxd;
  assign wr_mode  = reg_we_i && (reg_addr_i == A_MODE);
  assign wr_event = reg_we_i && (reg_addr_i == A_EVENT);
  assign wr_mask  = reg_we_i && (reg_addr_i == A_MASK);
  assign wr_txd   = reg_we_i && (reg_addr_i == A_TXD);
  assign rd_rxd   = reg_re_i && (reg_addr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      rx_thr_q <= '0;
      tx_thr_q <= '0;
      mask_q   <= '0;
    end else begin
      if (wr_mode) begin
        en_q     <= reg_wdata_i[MODE_EN_BIT];
        rx_thr_q <= reg_wdata_i[MODE_RX_LSB +: THR_W];
        tx_thr_q <= reg_wdata_i[MODE_TX_LSB +: THR_W];
      end
      if (wr_mask) mask_q <= reg_wdata_i;
    end
  end

  // transmit path
  logic tx_empty, tx_full;

  spi_evt_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en_q),
    .push_i  (wr_txd && en_q),
    .wdata_i (reg_wdata_i),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .empty_o (tx_empty),
    .full_o  (tx_full)
  );
  assign eng_tx_valid_o = !tx_empty;

  // receive path, each entry tagged with its valid byte count
  logic                rx_empty, rx_full;
  logic [RX_ENT_W-1:0] rx_head;
  logic [2:0]          rx_nb, rx_head_nb;
  logic                rx_push_ok, rx_pop_ok;

  assign rx_nb      = (eng_rx_bytes_i == 2'd0) ? 3'd4 : {1'b0, eng_rx_bytes_i};
  assign rx_head_nb = rx_head[WORD_W +: 3];
  assign rx_push_ok = eng_rx_push_i && en_q && !rx_full;
  assign rx_pop_ok  = rd_rxd && !rx_empty;

  spi_evt_fifo #(.WIDTH(RX_ENT_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!en_q),
    .push_i  (eng_rx_push_i && en_q),
    .wdata_i ({rx_nb, eng_rx_data_i}),
    .pop_i   (rd_rxd),
    .rdata_o (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rx_bytes_q <= '0;
    else if (!en_q) rx_bytes_q <= '0;
    else rx_bytes_q <= rx_bytes_q
                     + (rx_push_ok ? RXB_W'(rx_nb) : RXB_W'(0))
                     - (rx_pop_ok  ? RXB_W'(rx_head_nb) : RXB_W'(0));
  end

  // event flags
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q, flag_mask;

  always_comb begin
    flag_set            = '0;
    flag_set[IDX_ROOM]  = !tx_full;
    flag_set[IDX_AVAIL] = !rx_empty;
    flag_set[IDX_DONE]  = eng_frame_done_i;
    flag_set[IDX_DRAIN] = tx_empty;
    for (int i = 0; i < NFLAG; i++) begin
      flag_clr[i]  = wr_event && reg_wdata_i[FLAG_POS[i]];
      flag_mask[i] = mask_q[FLAG_POS[i]];
    end
  end

  spi_evt_flags #(.NFLAG(NFLAG)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .flags_o (flag_q)
  );

  assign irq_o = |(flag_q & flag_mask);

  // read mux
  logic [WORD_W-1:0] ev_word, mode_word;

  always_comb begin
    ev_word = '0;
    for (int i = 0; i < NFLAG; i++) ev_word[FLAG_POS[i]] = flag_q[i];
    ev_word[EV_CNT_LSB +: EV_CNT_W] = EV_CNT_W'(rx_bytes_q);
    mode_word = '0;
    mode_word[MODE_EN_BIT] = en_q;
    mode_word[MODE_RX_LSB +: THR_W] = rx_thr_q;
    mode_word[MODE_TX_LSB +: THR_W] = tx_thr_q;
  end

  always_comb begin
    case (reg_addr_i)
      A_MODE:  reg_rdata_o = mode_word;
      A_EVENT: reg_rdata_o = ev_word;
      A_MASK:  reg_rdata_o = mask_q;
      A_RXD:   reg_rdata_o = rx_empty ? '0 : rx_head[WORD_W-1:0];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_evt_stat_chk.sv
module spi_evt_stat_chk
  import spi_evt_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 8
) (
  input logic                                clk_i,
  input logic                                rst_ni,
  input logic                                en_i,
  input logic [31:0]                         mask_i,
  input logic [$clog2(4*RX_DEPTH+1)-1:0]     rx_bytes_i,
  input logic [NFLAG-1:0]                    flags_i,
  input logic                                irq_i,
  input logic                                frame_done_i,
  input logic                                rx_push_i,
  input logic                                rx_pop_i,
  input logic [2:0]                          push_bytes_i,
  input logic [2:0]                          head_bytes_i,
  input logic                                tx_full_i,
  input logic                                tx_empty_i,
  input logic                                rx_empty_i
);
  localparam int unsigned RXB_W = $clog2(4 * RX_DEPTH + 1);

  assert_tx_room_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_full_i |=> flags_i[IDX_ROOM]);

  assert_rx_avail_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_empty_i |=> flags_i[IDX_AVAIL]);

  assert_tx_drain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_i |=> flags_i[IDX_DRAIN]);

  assert_done_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_i |=> flags_i[IDX_DONE]);

  assert_cnt_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_bytes_i <= RXB_W'(4 * RX_DEPTH));

  assert_push_add_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i) |=>
      rx_bytes_i == RXB_W'($past(rx_bytes_i) + $past(push_bytes_i)));

  assert_pop_sub_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && !rx_push_i && en_i) |=>
      rx_bytes_i == RXB_W'($past(rx_bytes_i) - $past(head_bytes_i)));

  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> rx_bytes_i == '0);

  assert_mask_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i == '0 |-> !irq_i);
endmodule

bind spi_evt_stat spi_evt_stat_chk #(.RX_DEPTH(RX_DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_q),
  .mask_i       (mask_q),
  .rx_bytes_i   (rx_bytes_q),
  .flags_i      (flag_q),
  .irq_i        (irq_o),
  .frame_done_i (eng_frame_done_i),
  .rx_push_i    (rx_push_ok),
  .rx_pop_i     (rx_pop_ok),
  .push_bytes_i (rx_nb),
  .head_bytes_i (rx_head_nb),
  .tx_full_i    (tx_full),
  .tx_empty_i   (tx_empty),
  .rx_empty_i   (rx_empty)
);

// File: tb/spi_evt_stat_test.sv
`timescale 1ns/100ps
module spi_evt_stat_test;
  localparam int TXD = 4;
  localparam int RXD = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_valid;
  logic [31:0] tx_data;
  logic        tx_pop = 1'b0;
  logic        rx_push = 1'b0;
  logic [31:0] rx_data = '0;
  logic [1:0]  rx_bytes = '0;
  logic        fdone = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_evt_stat #(.TX_DEPTH(TXD), .RX_DEPTH(RXD)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_pop_i(tx_pop),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data), .eng_rx_bytes_i(rx_bytes),
    .eng_frame_done_i(fdone), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d, input logic [1:0] code);
    @(negedge clk); rx_push = 1'b1; rx_data = d; rx_bytes = code;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); fdone = 1'b1;
    @(negedge clk); fdone = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] mdata [RXD];
    int          mnb [RXD];
    int          mcnt, sum, stored;

    // R11 reset state
    repeat (3) @(negedge clk);
    rd(3'd0, v); chk("R11 mode", v, 32'h0);
    rd(3'd1, v); chk("R11 event", v, 32'h0);
    rd(3'd2, v); chk("R11 mask", v, 32'h0);
    chk("R11 irq", {31'b0, irq}, 32'h0);
    chk("R11 tx_valid", {31'b0, tx_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R9 mode layout
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R9 mode all ones", v, 32'h8000_3F3F);
    wr(3'd0, 32'h8000_0403); rd(3'd0, v); chk("R9 mode thresholds", v, 32'h8000_0403);
    wr(3'd2, 32'h1234_5678); rd(3'd2, v); chk("R9 mask readback", v, 32'h1234_5678);
    wr(3'd2, 32'h0);
    rd(3'd1, v); chk("R1 R3 idle event", v, 32'h0000_8100);

    // R1 R3 R7 tx sweep
    for (int n = 0; n <= TXD + 1; n++) begin
      for (int k = 0; k < n; k++) wr(3'd3, 32'hA000_0000 + k);
      stored = (n < TXD) ? n : TXD;
      wr(3'd1, 32'hFFFF_FFFF);
      rd(3'd1, v);
      chk("R1 R3 event after clear", v,
          ((stored < TXD) ? 32'h100 : 32'h0) | ((stored == 0) ? 32'h8000 : 32'h0));
      chk("R7 tx_valid", {31'b0, tx_valid}, (stored > 0) ? 32'h1 : 32'h0);
      for (int k = 0; k < stored; k++) begin
        #1 chk("R7 tx order", tx_data, 32'hA000_0000 + k);
        pop_tx();
      end
      chk("R7 tx drained", {31'b0, tx_valid}, 32'h0);
      @(negedge clk);
      rd(3'd1, v); chk("R1 R3 event refilled", v, 32'h0000_8100);
    end

    // R2 R5 R6 rx sweep over byte-count patterns
    for (int pat = 0; pat < 4; pat++) begin
      mcnt = 0; sum = 0;
      for (int k = 0; k <= RXD; k++) begin
        logic [1:0] code;
        code = 2'((k + pat) % 4);
        v = 32'hC0DE_0000 ^ (pat << 12) ^ k;
        push_rx(v, code);
        if (mcnt < RXD) begin
          mdata[mcnt] = v;
          mnb[mcnt] = (code == 0) ? 4 : int'(code);
          sum += mnb[mcnt];
          mcnt++;
        end
        rd(3'd1, v);
        chk("R5 byte count after push", (v >> 24) & 32'h3F, sum);
        chk("R2 rx present", (v >> 9) & 32'h1, 32'h1);
      end
      for (int j = 0; j < mcnt; j++) begin
        rd(3'd4, v); chk("R6 rx data order", v, mdata[j]);
        sum -= mnb[j];
        rd(3'd1, v); chk("R6 byte count after pop", (v >> 24) & 32'h3F, sum);
      end
      rd(3'd4, v); chk("R6 empty read", v, 32'h0);
      rd(3'd1, v); chk("R2 sticky after empty", v, 32'h0000_8300);
      wr(3'd1, 32'h0000_0200);
      rd(3'd1, v); chk("R2 cleared", v, 32'h0000_8100);
    end

    // R4 frame done
    pulse_done();
    rd(3'd1, v); chk("R4 done set", v, 32'h0000_C100);
    wr(3'd1, 32'h0000_8300);
    rd(3'd1, v); chk("R4 zero bit keeps done", v, 32'h0000_C100);
    wr(3'd1, 32'h0000_4000);
    rd(3'd1, v); chk("R4 done cleared", v, 32'h0000_8100);
    pulse_done();
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R4 clear all", v, 32'h0000_8100);

    // R10 mask table: flags room=1 avail=0 done=1 drain=1
    pulse_done();
    for (int m = 0; m < 16; m++) begin
      logic [31:0] mv;
      mv = (m & 1 ? 32'h100 : 0) | (m & 2 ? 32'h200 : 0) |
           (m & 4 ? 32'h4000 : 0) | (m & 8 ? 32'h8000 : 0);
      wr(3'd2, mv);
      #1 chk("R10 irq", {31'b0, irq}, ((m & 4'b1101) != 0) ? 32'h1 : 32'h0);
    end
    wr(3'd2, 32'h0);
    #1 chk("R10 zero mask", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h3F00_3CFF);
    #1 chk("R10 non-flag mask bits", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h0);

    // R8 disable flushes and blocks
    wr(3'd3, 32'h1111_1111); wr(3'd3, 32'h2222_2222);
    push_rx(32'h3333_3333, 2'd2); push_rx(32'h4444_4444, 2'd0);
    rd(3'd1, v); chk("R8 pre-disable count", (v >> 24) & 32'h3F, 32'd6);
    wr(3'd0, 32'h0000_0403);
    @(negedge clk);
    rd(3'd1, v); chk("R8 count flushed", (v >> 24) & 32'h3F, 32'h0);
    chk("R8 tx flushed", {31'b0, tx_valid}, 32'h0);
    wr(3'd3, 32'h5555_5555);
    push_rx(32'h6666_6666, 2'd1);
    wr(3'd0, 32'h8000_0403);
    @(negedge clk);
    chk("R8 tx empty after re-enable", {31'b0, tx_valid}, 32'h0);
    rd(3'd1, v); chk("R8 rx count after re-enable", (v >> 24) & 32'h3F, 32'h0);
    rd(3'd4, v); chk("R8 rx empty after re-enable", v, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule